// File: doc/BRIEF.md
# Transceiver power-cycle reset sequencer

This block removes and restores power on an external radio transceiver through a high-side supply switch. While it does so, it owns the transceiver's interface pins. These are the serial data-out line, the serial clock, the active-low chip select and the sleep/transmit strobe, each with its own output enable. The block holds these lines at safe levels in every phase, so that no driven-high line feeds current into an unpowered part. SPI transfers and the analog side of the supply are handled elsewhere.

A controller selects one of four operations on `op` and pulses `start` while the block is idle:
- a bare power cycle;
- a full reset, which is a power cycle followed by one more wait;
- an open sequence, which brings the interface up from the parked state and then runs a full reset;
- a close sequence, which cuts power and releases every pin.

`busy` is high while an operation runs. `done` pulses for one cycle when it ends. Every wait is a parameter in system clock cycles. The defaults match 100 ms and 10 ms at 125 MHz, and a bench can shrink them.

Top module: `xcvr_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first idle cycle after it is released, the block is parked. Parked means `vdd_off`=1, `mosi`=`sclk`=`sel_n`=`slp_tr`=0, `pin_oe`=4'h0, `busy`=0 and `done`=0. Asserting reset in the middle of an operation parks the block at once.
- R2: Operation codes on `op` are 0 (power cycle), 1 (full reset), 2 (open) and 3 (close). A `start` sampled high while idle begins the operation, and `busy` is high from the next cycle on.
- R3: A power cycle begins with one cycle in which `mosi`, `sclk`, `sel_n` and `slp_tr` are all driven low with `pin_oe`=4'hF, and `vdd_off` keeps its previous level. Only after that cycle does `vdd_off` rise.
- R4: After the low cycle, `vdd_off` stays high for T_DISCH cycles with all lines low. It then stays high for T_PRECH more cycles with `mosi`=1 and `sel_n`=1.
- R5: After the precharge phase, `vdd_off` falls and T_SETTLE cycles pass before the operation ends. A power cycle is therefore busy for 1+T_DISCH+T_PRECH+T_SETTLE cycles. A full reset adds T_EXTRA more cycles at the same pin levels.
- R6: Open first spends T_OPEN_PRE cycles with `vdd_off`=1, `sel_n`=1, `mosi`=`sclk`=`slp_tr`=0 and `pin_oe`=4'hF. It then spends T_OPEN_PWR cycles with `vdd_off`=0 at the same line levels, and then runs a full reset. Whenever `vdd_off` is 0, `pin_oe` is 4'hF.
- R7: Close asserts `vdd_off` for one cycle with the pins otherwise unchanged. It then drives all lines low with `pin_oe`=4'h0 and ends, so it is busy for exactly 2 cycles. The output enables never fall while power is on.
- R8: A `start` that arrives while `busy` is high is ignored, whatever `op` holds. The running operation keeps its length and its end levels.
- R9: `done` is high for exactly one cycle, in the first cycle with `busy` low. After a power cycle, full reset or open, the pins rest at `vdd_off`=0, `mosi`=1, `sel_n`=1, `sclk`=0, `slp_tr`=0 and `pin_oe`=4'hF until the next operation.
- R10: A power cycle started from the parked state drives all four lines (`pin_oe`=4'hF). Because power is already off, `vdd_off` is high for 1+T_DISCH+T_PRECH cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to begin the operation on `op`; honoured only while idle |
| op | input | 2 | Operation code: 0 power cycle, 1 full reset, 2 open, 3 close |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle pulse at the end of an operation |
| vdd_off | output | 1 | Supply switch control, high cuts transceiver power |
| mosi | output | 1 | Serial data-out line level |
| sclk | output | 1 | Serial clock line level |
| sel_n | output | 1 | Active-low chip select level |
| slp_tr | output | 1 | Sleep/transmit strobe level |
| pin_oe | output | 4 | Output enables: bit0 mosi, bit1 sclk, bit2 sel_n, bit3 slp_tr |

## Verification
The properties assume that `rst_n` is released away from the clock edge and that every delay parameter is at least 1. They also assume that `op` is stable in any cycle in which `start` is high and the block is idle. The stimulus changes `start`, `op` and `rst_n` only on falling clock edges and holds `op` steady with each request. The one late request, issued in the middle of a power cycle, deliberately carries a different `op` to show that a busy block ignores it. The bench shrinks every wait to a few tens of cycles with distinct values, so that a swapped or missing phase changes a measured duration.

// File: rtl/xps_pkg.sv
package xps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_O_PARK,
    ST_O_PWR,
    ST_C_LOW,
    ST_C_OFF,
    ST_C_PRE,
    ST_C_SETTLE,
    ST_C_EXTRA,
    ST_K_OFF,
    ST_K_PARK
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_CYCLE = 2'd0,
    OP_RESET = 2'd1,
    OP_OPEN  = 2'd2,
    OP_CLOSE = 2'd3
  } seq_op_e;

  // oe bit order: 0 mosi, 1 sclk, 2 sel_n, 3 slp_tr
  typedef struct packed {
    logic       vdd_off;
    logic       slp_tr;
    logic       sel_n;
    logic       sclk;
    logic       mosi;
    logic [3:0] oe;
  } pin_set_t;

  localparam pin_set_t PINS_PARKED = '{vdd_off: 1'b1, slp_tr: 1'b0, sel_n: 1'b0,
                                       sclk: 1'b0, mosi: 1'b0, oe: 4'h0};

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xps_timer.sv
module xps_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/xps_fsm.sv
module xps_fsm
  import xps_pkg::*;
#(
  parameter int T_DISCH    = 16,
  parameter int T_PRECH    = 4,
  parameter int T_SETTLE   = 4,
  parameter int T_EXTRA    = 4,
  parameter int T_OPEN_PRE = 4,
  parameter int T_OPEN_PWR = 4,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic             expired,
  output seq_st_e          st_q,
  output seq_st_e          st_d,
  output logic             full_q,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             done_q
);

  seq_op_e op_e;
  logic    full_d;
  logic    full_en;
  logic    done_d;
  logic    timed;
  int      dly;

  assign op_e = seq_op_e'(op);

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          unique case (op_e)
            OP_CYCLE, OP_RESET: st_d = ST_C_LOW;
            OP_OPEN:            st_d = ST_O_PARK;
            default:            st_d = ST_K_OFF;
          endcase
        end
      end
      ST_O_PARK:   if (expired) st_d = ST_O_PWR;
      ST_O_PWR:    if (expired) st_d = ST_C_LOW;
      ST_C_LOW:    st_d = ST_C_OFF;
      ST_C_OFF:    if (expired) st_d = ST_C_PRE;
      ST_C_PRE:    if (expired) st_d = ST_C_SETTLE;
      ST_C_SETTLE: if (expired) st_d = full_q ? ST_C_EXTRA : ST_IDLE;
      ST_C_EXTRA:  if (expired) st_d = ST_IDLE;
      ST_K_OFF:    st_d = ST_K_PARK;
      ST_K_PARK:   st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  // delay of the state being entered
  always_comb begin
    timed = 1'b1;
    unique case (st_d)
      ST_O_PARK:   dly = T_OPEN_PRE;
      ST_O_PWR:    dly = T_OPEN_PWR;
      ST_C_OFF:    dly = T_DISCH;
      ST_C_PRE:    dly = T_PRECH;
      ST_C_SETTLE: dly = T_SETTLE;
      ST_C_EXTRA:  dly = T_EXTRA;
      default: begin
        dly   = 1;
        timed = 1'b0;
      end
    endcase
    load     = timed && (st_d != st_q);
    load_val = CNT_W'(dly - 1);
  end

  assign full_en = (st_q == ST_IDLE) && start;
  assign full_d  = (op_e != OP_CYCLE);
  assign done_d  = (st_q != ST_IDLE) && (st_d == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full_q <= 1'b0;
    else if (full_en) full_q <= full_d;
  end

endmodule

// File: rtl/xps_pindrv.sv
module xps_pindrv
  import xps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  seq_st_e  st_d,
  output pin_set_t pins_q
);

  pin_set_t pins_d;
  logic     pins_en;

  always_comb begin
    pins_d = pins_q;
    unique case (st_d)
      ST_O_PARK:   pins_d = '{vdd_off: 1'b1, slp_tr: 1'b0, sel_n: 1'b1,
                              sclk: 1'b0, mosi: 1'b0, oe: 4'hF};
      ST_O_PWR:    pins_d = '{vdd_off: 1'b0, slp_tr: 1'b0, sel_n: 1'b1,
                              sclk: 1'b0, mosi: 1'b0, oe: 4'hF};
      ST_C_LOW:    pins_d = '{vdd_off: pins_q.vdd_off, slp_tr: 1'b0, sel_n: 1'b0,
                              sclk: 1'b0, mosi: 1'b0, oe: 4'hF};
      ST_C_OFF:    pins_d = '{vdd_off: 1'b1, slp_tr: 1'b0, sel_n: 1'b0,
                              sclk: 1'b0, mosi: 1'b0, oe: 4'hF};
      ST_C_PRE:    pins_d = '{vdd_off: 1'b1, slp_tr: 1'b0, sel_n: 1'b1,
                              sclk: 1'b0, mosi: 1'b1, oe: 4'hF};
      ST_C_SETTLE,
      ST_C_EXTRA:  pins_d = '{vdd_off: 1'b0, slp_tr: 1'b0, sel_n: 1'b1,
                              sclk: 1'b0, mosi: 1'b1, oe: 4'hF};
      ST_K_OFF:    pins_d.vdd_off = 1'b1;
      ST_K_PARK:   pins_d = PINS_PARKED;
      default:     pins_d = pins_q;
    endcase
  end

  assign pins_en = (st_d != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pins_q <= PINS_PARKED;
    else if (pins_en) pins_q <= pins_d;
  end

endmodule

// File: rtl/xcvr_pwr_seq.sv
module xcvr_pwr_seq
  import xps_pkg::*;
#(
  parameter int T_DISCH    = 12_500_000,
  parameter int T_PRECH    = 1_250_000,
  parameter int T_SETTLE   = 1_250_000,
  parameter int T_EXTRA    = 1_250_000,
  parameter int T_OPEN_PRE = 1_250_000,
  parameter int T_OPEN_PWR = 1_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  output logic       busy,
  output logic       done,
  output logic       vdd_off,
  output logic       mosi,
  output logic       sclk,
  output logic       sel_n,
  output logic       slp_tr,
  output logic [3:0] pin_oe
);

  localparam int MAX_DLY = max2(max2(max2(T_DISCH, T_PRECH), max2(T_SETTLE, T_EXTRA)),
                                max2(T_OPEN_PRE, T_OPEN_PWR));
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  seq_st_e          st_q;
  seq_st_e          st_d;
  logic             full_q;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic             done_q;
  pin_set_t         pins_q;

  xps_fsm #(
    .T_DISCH   (T_DISCH),
    .T_PRECH   (T_PRECH),
    .T_SETTLE  (T_SETTLE),
    .T_EXTRA   (T_EXTRA),
    .T_OPEN_PRE(T_OPEN_PRE),
    .T_OPEN_PWR(T_OPEN_PWR),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .expired (expired),
    .st_q    (st_q),
    .st_d    (st_d),
    .full_q  (full_q),
    .load    (load),
    .load_val(load_val),
    .done_q  (done_q)
  );

  xps_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(load_val),
    .expired (expired)
  );

  xps_pindrv u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .st_d  (st_d),
    .pins_q(pins_q)
  );

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign vdd_off = pins_q.vdd_off;
  assign mosi    = pins_q.mosi;
  assign sclk    = pins_q.sclk;
  assign sel_n   = pins_q.sel_n;
  assign slp_tr  = pins_q.slp_tr;
  assign pin_oe  = pins_q.oe;

endmodule

// File: rtl/xcvr_pwr_seq_chk.sv
module xcvr_pwr_seq_chk
  import xps_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       vdd_off,
  input logic       mosi,
  input logic       sclk,
  input logic       sel_n,
  input logic       slp_tr,
  input logic [3:0] pin_oe,
  input seq_st_e    st_q,
  input logic       full_q
);

  // R3
  lines_low_before_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vdd_off) && st_q == ST_C_OFF) |-> $past(!mosi && !sclk && !sel_n && !slp_tr));

  // R4
  precharge_before_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vdd_off) && st_q == ST_C_SETTLE) |-> $past(mosi && sel_n && st_q == ST_C_PRE));

  // R6
  powered_lines_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_off |-> (pin_oe == 4'hF));

  // R7
  release_after_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|pin_oe) |-> (vdd_off && $past(vdd_off)));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(full_q));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind xcvr_pwr_seq xcvr_pwr_seq_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .vdd_off(vdd_off),
  .mosi   (mosi),
  .sclk   (sclk),
  .sel_n  (sel_n),
  .slp_tr (slp_tr),
  .pin_oe (pin_oe),
  .st_q   (st_q),
  .full_q (full_q)
);

// File: tb/xcvr_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_pwr_seq_tb_top;

  localparam int D  = 20;
  localparam int P  = 7;
  localparam int S  = 5;
  localparam int X  = 4;
  localparam int OP = 6;
  localparam int OW = 3;

  localparam int CYC_BUSY  = 1 + D + P + S;
  localparam int RST_BUSY  = CYC_BUSY + X;
  localparam int OPEN_BUSY = OP + OW + RST_BUSY;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] nbusy;
    logic [15:0] noff;
    logic [15:0] npre;
    logic [3:0]  fin_oe;
    logic        fin_vdd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 16'(OPEN_BUSY), 16'(OP + D + P),     16'(P), 4'hF, 1'b0},
    '{2'd0, 16'(CYC_BUSY),  16'(D + P),          16'(P), 4'hF, 1'b0},
    '{2'd1, 16'(RST_BUSY),  16'(D + P),          16'(P), 4'hF, 1'b0},
    '{2'd3, 16'd2,          16'd2,               16'd1,  4'h0, 1'b1},
    '{2'd3, 16'd2,          16'd2,               16'd0,  4'h0, 1'b1},
    '{2'd0, 16'(CYC_BUSY),  16'(1 + D + P),      16'(P), 4'hF, 1'b0},
    '{2'd2, 16'(OPEN_BUSY), 16'(OP + D + P),     16'(P), 4'hF, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'd0;
  logic       busy, done, vdd_off, mosi, sclk, sel_n, slp_tr;
  logic [3:0] pin_oe;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xcvr_pwr_seq #(
    .T_DISCH(D), .T_PRECH(P), .T_SETTLE(S), .T_EXTRA(X),
    .T_OPEN_PRE(OP), .T_OPEN_PWR(OW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .busy(busy), .done(done), .vdd_off(vdd_off), .mosi(mosi),
    .sclk(sclk), .sel_n(sel_n), .slp_tr(slp_tr), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act %0d exp %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_parked(input string tag);
    check(tag, "busy", int'(busy), 0);
    check(tag, "done", int'(done), 0);
    check(tag, "vdd_off", int'(vdd_off), 1);
    check(tag, "pin_oe", int'(pin_oe), 0);
    check(tag, "lines", int'({mosi, sclk, sel_n, slp_tr}), 0);
  endtask

  task automatic run_op(input logic [1:0] o, input int inject_at,
                        output int nb, output int noff, output int npre,
                        output int lowbad, output int first_busy);
    logic prev_vdd;
    logic prev_lines;
    @(negedge clk);
    start = 1'b1;
    op    = o;
    @(negedge clk);
    start = 1'b0;
    nb = 0; noff = 0; npre = 0; lowbad = 0;
    first_busy = int'(busy);
    prev_vdd   = vdd_off;
    prev_lines = 1'b0;
    for (int g = 0; g < 5000; g++) begin
      if (done) break;
      if (busy) begin
        nb++;
        if (vdd_off) noff++;
        if (vdd_off && mosi && sel_n) npre++;
        if (vdd_off && !prev_vdd && prev_lines) lowbad++;
      end
      prev_vdd   = vdd_off;
      prev_lines = mosi | sclk | sel_n | slp_tr;
      if (nb == inject_at) begin
        start = 1'b1;
        op    = 2'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int nb, noff, npre, lowbad, fb;
    string t_len;
    repeat (3) @(negedge clk);
    check_parked("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_parked("R1");

    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].op, -1, nb, noff, npre, lowbad, fb);
      t_len = (VECS[v].op == 2'd2) ? "R6" : (VECS[v].op == 2'd3) ? "R7" : "R5";
      check("R2", $sformatf("v%0d busy after start", v), fb, 1);
      check(t_len, $sformatf("v%0d busy cycles", v), nb, int'(VECS[v].nbusy));
      check((v == 5) ? "R10" : "R4", $sformatf("v%0d vdd_off cycles", v), noff, int'(VECS[v].noff));
      check("R4", $sformatf("v%0d precharge cycles", v), npre, int'(VECS[v].npre));
      if (VECS[v].op[1] == 1'b0)
        check("R3", $sformatf("v%0d lines high at cut", v), lowbad, 0);
      check("R9", $sformatf("v%0d done with busy low", v), int'({done, busy}), 2);
      check((VECS[v].op == 2'd3) ? "R7" : "R9", $sformatf("v%0d final oe", v),
            int'(pin_oe), int'(VECS[v].fin_oe));
      check((VECS[v].op == 2'd3) ? "R7" : "R9", $sformatf("v%0d final vdd_off", v),
            int'(vdd_off), int'(VECS[v].fin_vdd));
      if (VECS[v].op != 2'd3)
        check("R9", $sformatf("v%0d rest lines", v),
              int'({mosi, sclk, sel_n, slp_tr}), 4'b1010);
      @(negedge clk);
      check("R9", $sformatf("v%0d done width", v), int'(done), 0);
    end

    // R8: close request in the middle of a power cycle is ignored
    run_op(2'd0, 10, nb, noff, npre, lowbad, fb);
    check("R8", "busy cycles with late start", nb, CYC_BUSY);
    check("R8", "oe after ignored close", int'(pin_oe), 15);
    check("R8", "vdd_off after ignored close", int'(vdd_off), 0);
    @(negedge clk);
    check("R8", "no second run", int'(busy), 0);

    // R1: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1;
    op    = 2'd1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_parked("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_parked("R1");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule